// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down-counter that moves only on cycles where the counting clock enable is high. A host-side controller (not part of this block) writes a new count with a one-cycle load strobe. The same strobe captures a three-bit operating mode and a binary/BCD select. The channel then produces a level or pulse on its waveform output, following the rules of the selected mode. These modes cover a one-shot terminal-count interrupt, a gate-retriggerable one-shot, a rate generator, a square-wave generator, and software- or gate-triggered strobes.

A loaded count does not reach the counter at once. It moves in on a later enable tick: the next one, or, in the gate-triggered modes, the first tick after a rising edge on the gate. Until that transfer happens, a pending-count flag stays raised. A loaded value of zero acts as the largest count: 65536 in binary and 10000 in BCD. In the non-periodic modes the counter runs on past zero and wraps, while the periodic modes reload themselves.

Top module: `interval_counter_channel`

## Requirements
- R1: A load strobe captures the value, mode and BCD select, and raises `null_cnt` in the next cycle. In modes 0, 2, 3 and 4 the next tick copies the value into `count_val` and clears `null_cnt`.
- R2: A loaded zero reads as 0000 after transfer and steps to FFFF (binary) or 9999 (BCD) on the next tick, so one full run takes 65536 or 10000 ticks.
- R3: With BCD set, each 4-bit digit borrows from the next, so 1000 steps to 0999.
- R4: Mode 0 drives `wave_out` low on load. It goes high on the tick where the count reaches 0, stays high, and the counter keeps wrapping.
- R5: In modes 0, 2, 3 and 4, a tick with `gate` low leaves the count unchanged.
- R6: In modes 1 and 5 the count is transferred only on the first tick after a gate rising edge. In mode 1 `wave_out` is low from that tick until the count reaches 0. A later rising edge restarts from the loaded value.
- R7: Mode 2 has a period of N ticks. `wave_out` is low only while the count is 1, then the count reloads N. It is high at the transfer.
- R8: Mode 3 steps the count by two. `wave_out` is high for ceil(N/2) ticks and low for floor(N/2) ticks of each N-tick period. For an odd N, the low half starts from N-1.
- R9: In modes 4 and 5, `wave_out` is low for exactly one tick when the count first reaches 0 after a transfer or trigger, and not again on later wraps.
- R10: Mode codes 6 and 7 behave as codes 2 and 3.
- R11: When a load strobe and a tick fall in the same cycle, the tick acts on the old state and the new load wins. `null_cnt` stays set, `wave_out` takes its load value, and the following tick transfers the new count.
- R12: After reset `count_val` is 0000, `wave_out` is high and `null_cnt` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting clock enable (one tick) |
| load_stb | input | 1 | Count write strobe; captures value, mode and BCD select |
| load_val | input | 16 | Initial count |
| mode_sel | input | 3 | Operating mode code (6 and 7 alias 2 and 3) |
| bcd_sel | input | 1 | 1 selects four-digit BCD counting |
| gate | input | 1 | Gate level; enable in modes 0/2/3/4, rising edge triggers in 1/2/3/5 |
| count_val | output | 16 | Live counter value |
| wave_out | output | 1 | Channel waveform output |
| null_cnt | output | 1 | High while a written count waits to be transferred |

## Verification
The collision of interest is a count write landing in the same cycle as a counting tick while the channel is running in the rate-generator mode. The bench provokes it by issuing both strobes on one cycle, one tick after a transfer. It then expects the old count to have stepped once, `null_cnt` to be high and the output to show its load level. The next tick must bring in the new value. The gate edge and the tick are a second overlap that the bench also drives on one cycle. For that case the expected result is a restart rather than a step.

// File: rtl/ictr_pkg.sv
`timescale 1ns/1ps
package ictr_pkg;

  typedef enum logic [2:0] {
    M_TC_FLAG   = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } mode_e;

  // codes above 5 fold onto the periodic modes
  function automatic mode_e fold_mode(input logic [2:0] code);
    return (code > 3'd5) ? mode_e'(code - 3'd4) : mode_e'(code);
  endfunction

endpackage

// File: rtl/ictr_gate_edge.sv
`timescale 1ns/1ps
module ictr_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic tick,
  output logic trig_now
);
  logic gate_q;
  logic pend_q;
  logic rise;

  assign rise     = gate & ~gate_q;
  assign trig_now = pend_q | rise;

  // a rising edge is held until the next counting tick consumes it
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate;
      pend_q <= tick ? 1'b0 : (pend_q | rise);
    end
  end
endmodule

// File: rtl/ictr_step.sv
`timescale 1ns/1ps
module ictr_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  input  logic         dbl,
  output logic [W-1:0] res
);
  localparam int DIG = W / 4;
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [2:0][W-1:0]   bq;
  logic [1:0][DIG-1:0] br;

  assign bq[0] = val;

  // two cascaded per-digit decimal decrementers
  for (genvar s = 0; s < 2; s++) begin : g_stage
    assign br[s][0] = 1'b1;
    for (genvar i = 0; i < DIG; i++) begin : g_dig
      logic [3:0] dg;
      assign dg = bq[s][4*i +: 4];
      assign bq[s+1][4*i +: 4] = br[s][i] ? ((dg == 4'd0) ? 4'd9 : dg - 4'd1) : dg;
      if (i < DIG - 1) begin : g_bor
        assign br[s][i+1] = br[s][i] & (dg == 4'd0);
      end
    end
  end

  assign res = bcd ? (dbl ? bq[2] : bq[1]) : (val - (dbl ? TWO : ONE));
endmodule

// File: rtl/interval_counter_channel.sv
`timescale 1ns/1ps
module interval_counter_channel
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         load_stb,
  input  logic [W-1:0] load_val,
  input  logic [2:0]   mode_sel,
  input  logic         bcd_sel,
  input  logic         gate,
  output logic [W-1:0] count_val,
  output logic         wave_out,
  output logic         null_cnt
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  mode_e        mode_q;
  logic         bcd_q;
  logic [W-1:0] init_q;
  logic [W-1:0] cnt_q;
  logic         out_q;
  logic         null_q;
  logic         run_q;
  logic         armed_q;

  logic         trig_now;
  logic [W-1:0] cnt_dec;
  logic [W-1:0] init_m1;
  logic         need_trig;
  logic         retrig_mode;
  logic         gate_ok;
  logic         xfer;
  logic         restart;
  logic         step;
  mode_e        new_mode;

  ictr_gate_edge u_gate (
    .clk      (clk),
    .rst      (rst),
    .gate     (gate),
    .tick     (cnt_en),
    .trig_now (trig_now)
  );

  ictr_step #(.W(W)) u_step (
    .val (cnt_q),
    .bcd (bcd_q),
    .dbl (mode_q == M_SQUARE),
    .res (cnt_dec)
  );

  ictr_step #(.W(W)) u_half (
    .val (init_q),
    .bcd (bcd_q),
    .dbl (1'b0),
    .res (init_m1)
  );

  assign new_mode    = fold_mode(mode_sel);
  assign need_trig   = (mode_q == M_ONESHOT) || (mode_q == M_HW_STROBE);
  assign retrig_mode = need_trig || (mode_q == M_RATE) || (mode_q == M_SQUARE);
  assign gate_ok     = need_trig | gate;
  assign xfer        = cnt_en & null_q & (~need_trig | trig_now);
  assign restart     = cnt_en & ~null_q & run_q & trig_now & retrig_mode;
  assign step        = cnt_en & run_q & ~null_q & ~restart & gate_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_TC_FLAG;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b1;
      null_q  <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (xfer || restart) begin
        cnt_q   <= init_q;
        run_q   <= 1'b1;
        null_q  <= 1'b0;
        armed_q <= 1'b1;
        out_q   <= !((mode_q == M_TC_FLAG) || (mode_q == M_ONESHOT));
      end else if (step) begin
        unique case (mode_q)
          M_TC_FLAG, M_ONESHOT: begin
            cnt_q <= cnt_dec;
            if (cnt_dec == '0) out_q <= 1'b1;
          end
          M_RATE: begin
            if (cnt_q == ONE) begin
              cnt_q <= init_q;
              out_q <= 1'b1;
            end else begin
              cnt_q <= cnt_dec;
              out_q <= (cnt_dec != ONE);
            end
          end
          M_SQUARE: begin
            if (cnt_q == ONE || cnt_q == TWO) begin
              out_q <= ~out_q;
              cnt_q <= (out_q && init_q[0]) ? init_m1 : init_q;
            end else begin
              cnt_q <= cnt_dec;
            end
          end
          default: begin
            cnt_q <= cnt_dec;
            if (armed_q && cnt_dec == '0) begin
              out_q   <= 1'b0;
              armed_q <= 1'b0;
            end else begin
              out_q <= 1'b1;
            end
          end
        endcase
      end
      // a write overrides whatever the tick did to the control state
      if (load_stb) begin
        init_q  <= load_val;
        mode_q  <= new_mode;
        bcd_q   <= bcd_sel;
        null_q  <= 1'b1;
        run_q   <= 1'b0;
        armed_q <= 1'b0;
        out_q   <= (new_mode != M_TC_FLAG);
      end
    end
  end

  assign count_val = cnt_q;
  assign wave_out  = out_q;
  assign null_cnt  = null_q;

  AST_NULL_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> null_cnt); // R1

  AST_M0_OUT_STAYS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_TC_FLAG && wave_out && !load_stb) |=> wave_out); // R4

  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !gate && !load_stb && !null_q &&
     (mode_q == M_TC_FLAG || mode_q == M_SW_STROBE)) |=> $stable(count_val)); // R5

  AST_RATE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RATE && !wave_out && cnt_en && gate && !load_stb) |=> wave_out); // R7

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_SW_STROBE || mode_q == M_HW_STROBE) && !wave_out && cnt_en &&
     (gate || mode_q == M_HW_STROBE) && !load_stb) |=> wave_out); // R9

  AST_MODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    mode_q <= M_HW_STROBE); // R10
endmodule

// File: tb/interval_counter_channel_test.sv
`timescale 1ns/1ps
module interval_counter_channel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode_sel = '0;
  logic        bcd_sel = 1'b0;
  logic        gate = 1'b0;
  logic [15:0] count_val;
  logic        wave_out;
  logic        null_cnt;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  interval_counter_channel uut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load_stb(load_stb),
    .load_val(load_val), .mode_sel(mode_sel), .bcd_sel(bcd_sel), .gate(gate),
    .count_val(count_val), .wave_out(wave_out), .null_cnt(null_cnt)
  );

  function automatic logic [44:0] v(input logic ld, input logic [15:0] val,
      input logic [2:0] md, input logic bcd, input logic gt, input logic tk,
      input logic [15:0] ec, input logic eo, input logic en, input logic [3:0] rq);
    return {ld, val, md, bcd, gt, tk, ec, eo, en, rq};
  endfunction

  // fields: load, value, mode, bcd, gate, tick | count, out, null, requirement
  localparam logic [44:0] TBL [23] = '{
    v(1, 16'h0003, 3'd0, 0, 1, 0, 16'h0000, 0, 1, 4'd1),  // R1 mode 0 load
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0003, 0, 0, 4'd1),  // R1 transfer
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0002, 0, 0, 4'd4),
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0001, 0, 0, 4'd4),
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0000, 1, 0, 4'd4),  // R4 terminal
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'hFFFF, 1, 0, 4'd4),  // R4 wrap, stays high
    v(0, 16'h0000, 3'd0, 0, 0, 1, 16'hFFFF, 1, 0, 4'd5),  // R5 gate low holds
    v(1, 16'h0003, 3'd2, 0, 1, 0, 16'hFFFF, 1, 1, 4'd7),  // R7 load
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0003, 1, 0, 4'd7),  // R7 no pulse at load
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0002, 1, 0, 4'd7),
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0001, 0, 0, 4'd7),  // R7 pulse
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0003, 1, 0, 4'd7),  // R7 reload
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0002, 1, 0, 4'd7),
    v(1, 16'h0005, 3'd7, 0, 1, 0, 16'h0002, 1, 1, 4'd10), // R10 code 7
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0005, 1, 0, 4'd8),
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0003, 1, 0, 4'd8),  // R8 step of two
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0001, 1, 0, 4'd8),
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0004, 0, 0, 4'd8),  // R8 low half from N-1
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0002, 0, 0, 4'd8),
    v(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0005, 1, 0, 4'd8),  // R8 period 5
    v(1, 16'h1000, 3'd0, 1, 1, 0, 16'h0005, 0, 1, 4'd3),
    v(0, 16'h0000, 3'd0, 1, 1, 1, 16'h1000, 0, 0, 4'd3),
    v(0, 16'h0000, 3'd0, 1, 1, 1, 16'h0999, 0, 0, 4'd3)   // R3 digit borrow
  };

  task automatic drive(input logic ld, input logic [15:0] val, input logic [2:0] md,
                       input logic bcd, input logic gt, input logic tk);
    load_stb = ld; load_val = val; mode_sel = md; bcd_sel = bcd; gate = gt; cnt_en = tk;
  endtask

  task automatic apply(input logic ld, input logic [15:0] val, input logic [2:0] md,
                       input logic bcd, input logic gt, input logic tk,
                       input logic [15:0] ec, input logic eo, input logic en,
                       input string rq);
    drive(ld, val, md, bcd, gt, tk);
    @(negedge clk);
    nvec++;
    if (count_val !== ec || wave_out !== eo || null_cnt !== en) begin
      nbad++;
      $display("FAIL %s: count=%h out=%b null=%b expected count=%h out=%b null=%b",
               rq, count_val, wave_out, null_cnt, ec, eo, en);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic        t_ld, t_bcd, t_gt, t_tk, t_eo, t_en;
    logic [15:0] t_val, t_ec;
    logic [2:0]  t_md;
    logic [3:0]  t_rq;

    drive(0, 16'h0000, 3'd0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    apply(0, 16'h0000, 3'd0, 0, 0, 0, 16'h0000, 1, 0, "R12");  // R12 reset state

    for (int k = 0; k < 23; k++) begin
      {t_ld, t_val, t_md, t_bcd, t_gt, t_tk, t_ec, t_eo, t_en, t_rq} = TBL[k];
      apply(t_ld, t_val, t_md, t_bcd, t_gt, t_tk, t_ec, t_eo, t_en,
            $sformatf("R%0d", t_rq));
    end

    // R2: zero means full range, binary then BCD
    apply(1, 16'h0000, 3'd0, 0, 1, 0, 16'h0999, 0, 1, "R2");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0000, 0, 0, "R2");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'hFFFF, 0, 0, "R2");
    apply(1, 16'h0000, 3'd0, 1, 1, 0, 16'hFFFF, 0, 1, "R2");
    apply(0, 16'h0000, 3'd0, 1, 1, 1, 16'h0000, 0, 0, "R2");
    apply(0, 16'h0000, 3'd0, 1, 1, 1, 16'h9999, 0, 0, "R2");

    // R6: mode 1 waits for a gate edge, then retriggers
    apply(0, 16'h0000, 3'd0, 0, 0, 1, 16'h9999, 0, 0, "R5");
    apply(1, 16'h0004, 3'd1, 0, 0, 0, 16'h9999, 1, 1, "R6");
    apply(0, 16'h0000, 3'd0, 0, 0, 1, 16'h9999, 1, 1, "R6");
    apply(0, 16'h0000, 3'd0, 0, 1, 0, 16'h9999, 1, 1, "R6");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0004, 0, 0, "R6");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0003, 0, 0, "R6");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0002, 0, 0, "R6");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0001, 0, 0, "R6");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0000, 1, 0, "R6");
    apply(0, 16'h0000, 3'd0, 0, 0, 0, 16'h0000, 1, 0, "R6");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0004, 0, 0, "R6");  // edge and tick together

    // R9: mode 4 strobes once, R5 gate hold in mode 4
    apply(1, 16'h0002, 3'd4, 0, 1, 0, 16'h0004, 1, 1, "R9");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0002, 1, 0, "R9");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0001, 1, 0, "R9");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0000, 0, 0, "R9");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'hFFFF, 1, 0, "R9");
    apply(0, 16'h0000, 3'd0, 0, 0, 1, 16'hFFFF, 1, 0, "R5");
    drive(0, 16'h0000, 3'd0, 0, 1, 1);
    repeat (65534) @(negedge clk);
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0000, 1, 0, "R9");  // second zero, no strobe

    // R9: mode 5 needs a gate edge
    apply(0, 16'h0000, 3'd0, 0, 0, 1, 16'h0000, 1, 0, "R5");
    apply(1, 16'h0002, 3'd5, 0, 0, 0, 16'h0000, 1, 1, "R9");
    apply(0, 16'h0000, 3'd0, 0, 0, 1, 16'h0000, 1, 1, "R9");
    apply(0, 16'h0000, 3'd0, 0, 1, 0, 16'h0000, 1, 1, "R9");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0002, 1, 0, "R9");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0001, 1, 0, "R9");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0000, 0, 0, "R9");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'hFFFF, 1, 0, "R9");

    // R10: code 6 runs as rate generator
    apply(1, 16'h0002, 3'd6, 0, 1, 0, 16'hFFFF, 1, 1, "R10");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0002, 1, 0, "R10");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0001, 0, 0, "R10");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0002, 1, 0, "R10");

    // R11: load and tick in the same cycle
    apply(1, 16'h0006, 3'd2, 0, 1, 0, 16'h0002, 1, 1, "R11");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0006, 1, 0, "R11");
    apply(1, 16'h0004, 3'd2, 0, 1, 1, 16'h0005, 1, 1, "R11");
    apply(0, 16'h0000, 3'd0, 0, 1, 1, 16'h0004, 1, 0, "R11");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule